// File: doc/BRIEF.md
# Three-Wire Serial Clock-Chip Master

This block is a hardware master for a timekeeping chip reached over three wires: an enable strobe, a serial clock and one bidirectional data line. The host pulses a start strobe together with a command byte and a data-byte count. The master raises the enable strobe and shifts the command out. It then either shifts the requested number of data bytes out from the host (write) or shifts them in from the chip (read). Finally it drops the strobe and reports completion. One command byte with one data byte gives a single-register access. The same sequence with a larger count gives a burst.

All bytes travel least significant bit first, eight clock pulses per byte. The command byte is sent as given. Its layout is: bit 7 always 1, bit 6 always 0, bits 5:4 equal to 00 for a single register or 11 for a burst, bits 3:1 the register address, and bit 0 the direction (1 read, 0 write). Only bit 0 is interpreted here, and it selects the direction of the data phase. Outgoing bits change while the serial clock is low. Incoming bits, which the chip presents after a falling edge, are sampled in the last system cycle of the high half. The serial clock half-period is a parameter counted in system clocks.

Top module: `tw_master`

## Requirements
- R1: After reset, enable, serial clock and data output-enable are low, and busy, done, write-take and read-valid are low.
- R2: The command byte goes out LSB first, one bit per rising serial-clock edge, with the output-enable high. The data output does not change while the serial clock is high.
- R3: The enable strobe is high for at least one half-period before the first rising edge and stays high until after the last falling edge. There is no rising edge while enable is low, and the clock, enable and output-enable are all low once the transaction ends.
- R4: With command bit 0 equal to 0, `count_i` data bytes follow the command. Each is taken from `wdata_i` and sent LSB first, and a one-cycle `wtake_o` pulse marks each byte taken, after which the host presents the next one. A transaction has 8*(1+`count_i`) rising edges and no `rvalid_o` pulse.
- R5: With command bit 0 equal to 1, `count_i` bytes are received after the command, bit 0 first. Each finished byte is shown on `rdata_o` with a one-cycle `rvalid_o` pulse, and there is no `wtake_o` pulse.
- R6: After the last transmitted bit, the data output goes low before the output-enable falls. The output-enable is low at every rising edge of a read data phase.
- R7: The serial clock idles low. Each high half and each low half after the first rising edge lasts exactly `HALF_DIV` system clocks.
- R8: A start pulse while busy is ignored. It does not change the running transaction and does not start another one.
- R9: Busy is high from the cycle after an accepted start through the done cycle. Done is high for exactly one cycle, the first cycle in which enable is low, and busy is low in the cycle after it.
- R10: A count of zero sends only the command byte (8 rising edges), with no write-take and no read-valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted only when idle |
| cmd_i | input | 8 | Command byte, bit 0 = read |
| count_i | input | CNT_W | Number of data bytes after the command |
| wdata_i | input | 8 | Next byte to write |
| wtake_o | output | 1 | Pulse: `wdata_i` was taken |
| rdata_o | output | 8 | Received byte |
| rvalid_o | output | 1 | Pulse: `rdata_o` holds a new byte |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle end-of-transaction pulse |
| ce_o | output | 1 | Enable strobe to the chip |
| sclk_o | output | 1 | Serial clock to the chip |
| dout_o | output | 1 | Data line output value |
| doe_o | output | 1 | Data line output-enable |
| din_i | input | 1 | Data line input value |

## Verification
The bench builds the block with `HALF_DIV` = 3 and `CNT_W` = 4. The odd divider gives high and low halves of three cycles each, so an off-by-one in the divider or in the setup half shows up directly in the measured widths. A 4-bit count reaches the 8-byte burst read, the 7-byte burst write and the zero-count case, and it also allows random counts up to 9. A behavioural chip model drives random bits on the data line outside the read phase, which exposes sampling at the wrong time or in the wrong direction.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned BIT_W  = $clog2(BYTE_W);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W - 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_HIGH, ST_LOW, ST_HOLD, ST_FIN
  } tw_state_e;

  typedef enum logic [1:0] {
    SR_NOP, SR_LOAD, SR_TX, SR_RX
  } tw_sr_op_e;
endpackage

// File: rtl/tw_tick.sv
module tw_tick #(
  parameter int unsigned HALF_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int unsigned CW = $clog2(HALF_DIV + 1);
  localparam logic [CW-1:0] TOP = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!run_i)         cnt_q <= '0;
    else if (cnt_q == TOP)   cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = run_i && (cnt_q == TOP);

  generate
    if (HALF_DIV > 1) begin : g_gap
      // R7
      tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/tw_shreg.sv
module tw_shreg
  import tw_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  tw_sr_op_e         op_i,
  input  logic [BYTE_W-1:0] load_i,
  input  logic              ser_i,
  output logic [BYTE_W-1:0] q_o
);
  logic [BYTE_W-1:0] q_q;

  // LSB leaves first; received bits enter at the MSB and walk down
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else begin
      unique case (op_i)
        SR_LOAD: q_q <= load_i;
        SR_TX:   q_q <= {1'b0, q_q[BYTE_W-1:1]};
        SR_RX:   q_q <= {ser_i, q_q[BYTE_W-1:1]};
        default: q_q <= q_q;
      endcase
    end
  end

  assign q_o = q_q;
endmodule

// File: rtl/tw_ctrl.sv
module tw_ctrl
  import tw_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [BYTE_W-1:0] cmd_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              tick_i,
  output logic              run_o,
  output tw_sr_op_e         sr_op_o,
  output logic [BYTE_W-1:0] sr_load_o,
  output logic              wtake_o,
  output logic              rvalid_o,
  output logic              ce_o,
  output logic              sclk_o,
  output logic              oe_o,
  output logic              tx_act_o,
  output logic              busy_o,
  output logic              done_o
);
  tw_state_e        state_q;
  logic [BIT_W-1:0] bit_q;
  logic [CNT_W-1:0] left_q;
  logic             cmd_ph_q, rd_q, ce_q, sclk_q, oe_q, tx_q, rel_q;
  logic             wtake_q, rvalid_q;

  logic rx_ph, more_after, need_load, byte_end;

  assign rx_ph      = rd_q && !cmd_ph_q;
  assign more_after = cmd_ph_q ? (left_q != '0) : (left_q > CNT_W'(1));
  assign need_load  = !rd_q && more_after;
  assign byte_end   = (bit_q == LAST_BIT);

  always_comb begin
    sr_op_o   = SR_NOP;
    sr_load_o = wdata_i;
    if (state_q == ST_IDLE && start_i) begin
      sr_op_o   = SR_LOAD;
      sr_load_o = cmd_i;
    end else if (state_q == ST_HIGH && tick_i) begin
      if (rx_ph)          sr_op_o = SR_RX;
      else if (!byte_end) sr_op_o = SR_TX;
      else if (need_load) sr_op_o = SR_LOAD;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      bit_q    <= '0;
      left_q   <= '0;
      cmd_ph_q <= 1'b0;
      rd_q     <= 1'b0;
      ce_q     <= 1'b0;
      sclk_q   <= 1'b0;
      oe_q     <= 1'b0;
      tx_q     <= 1'b0;
      rel_q    <= 1'b0;
      wtake_q  <= 1'b0;
      rvalid_q <= 1'b0;
    end else begin
      wtake_q  <= 1'b0;
      rvalid_q <= 1'b0;
      rel_q    <= 1'b0;
      // line already parked low for one cycle, now let go
      if (rel_q) oe_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q  <= ST_SETUP;
          ce_q     <= 1'b1;
          oe_q     <= 1'b1;
          tx_q     <= 1'b1;
          cmd_ph_q <= 1'b1;
          rd_q     <= cmd_i[0];
          left_q   <= count_i;
          bit_q    <= '0;
        end
        ST_SETUP: if (tick_i) begin
          state_q <= ST_HIGH;
          sclk_q  <= 1'b1;
        end
        ST_HIGH: if (tick_i) begin
          sclk_q <= 1'b0;
          if (byte_end) begin
            bit_q    <= '0;
            cmd_ph_q <= 1'b0;
            if (!cmd_ph_q) left_q <= left_q - 1'b1;
            if (rx_ph) rvalid_q <= 1'b1;
            if (!more_after) begin
              state_q <= ST_HOLD;
              if (tx_q) begin
                tx_q  <= 1'b0;
                rel_q <= 1'b1;
              end
            end else begin
              state_q <= ST_LOW;
              if (cmd_ph_q && rd_q) begin
                tx_q  <= 1'b0;
                rel_q <= 1'b1;
              end
              if (need_load) wtake_q <= 1'b1;
            end
          end else begin
            bit_q   <= bit_q + 1'b1;
            state_q <= ST_LOW;
          end
        end
        ST_LOW: if (tick_i) begin
          state_q <= ST_HIGH;
          sclk_q  <= 1'b1;
        end
        ST_HOLD: if (tick_i) begin
          state_q <= ST_FIN;
          ce_q    <= 1'b0;
        end
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign run_o    = (state_q != ST_IDLE) && (state_q != ST_FIN);
  assign wtake_o  = wtake_q;
  assign rvalid_o = rvalid_q;
  assign ce_o     = ce_q;
  assign sclk_o   = sclk_q;
  assign oe_o     = oe_q;
  assign tx_act_o = tx_q;
  assign busy_o   = (state_q != ST_IDLE);
  assign done_o   = (state_q == ST_FIN);

  // R3
  sclk_in_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_q |-> ce_q);
  // R6
  rx_no_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sclk_q) && rx_ph) |-> !oe_q);
  // R9
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R9
  done_after_ce_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!ce_q && $past(ce_q)));
  // R8
  busy_start_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> ($stable(rd_q) && busy_o));
endmodule

// File: rtl/tw_master.sv
module tw_master
  import tw_pkg::*;
#(
  parameter int unsigned HALF_DIV = 4,
  parameter int unsigned CNT_W    = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [BYTE_W-1:0] cmd_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic              wtake_o,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              ce_o,
  output logic              sclk_o,
  output logic              dout_o,
  output logic              doe_o,
  input  logic              din_i
);
  logic              tick, run, tx_act;
  tw_sr_op_e         sr_op;
  logic [BYTE_W-1:0] sr_load, sr_q;

  tw_tick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .tick_o (tick)
  );

  tw_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .cmd_i     (cmd_i),
    .count_i   (count_i),
    .wdata_i   (wdata_i),
    .tick_i    (tick),
    .run_o     (run),
    .sr_op_o   (sr_op),
    .sr_load_o (sr_load),
    .wtake_o   (wtake_o),
    .rvalid_o  (rvalid_o),
    .ce_o      (ce_o),
    .sclk_o    (sclk_o),
    .oe_o      (doe_o),
    .tx_act_o  (tx_act),
    .busy_o    (busy_o),
    .done_o    (done_o)
  );

  tw_shreg u_shreg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .op_i   (sr_op),
    .load_i (sr_load),
    .ser_i  (din_i),
    .q_o    (sr_q)
  );

  assign dout_o  = tx_act & sr_q[0];
  assign rdata_o = sr_q;

  // R2
  dout_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sclk_o && $past(sclk_o)) |-> $stable(dout_o));
  // R6
  release_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(doe_o) |-> !$past(dout_o));
endmodule

// File: tb/tw_master_tb.sv
module tw_master_tb;
  localparam int HALF = 3;
  localparam int CW   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [7:0] cmd = 8'h0;
  logic [CW-1:0] count = '0;
  logic [7:0] wdata;
  logic wtake, rvalid, busy, done, ce, sclk, dout, doe;
  logic [7:0] rdata;
  logic din = 1'b0;

  always #2 clk = ~clk;

  tw_master #(.HALF_DIV(HALF), .CNT_W(CW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .cmd_i(cmd), .count_i(count),
    .wdata_i(wdata), .wtake_o(wtake), .rdata_o(rdata), .rvalid_o(rvalid),
    .busy_o(busy), .done_o(done), .ce_o(ce), .sclk_o(sclk), .dout_o(dout),
    .doe_o(doe), .din_i(din)
  );

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  logic [7:0] wbytes [16];
  logic [7:0] rbytes [16];
  logic [7:0] wcap [16];
  logic [7:0] rcap [16];
  logic [4:0] widx = '0;
  assign wdata = wbytes[widx[3:0]];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // chip model and pad monitor
  logic p_sclk = 0, p_ce = 0, p_oe = 0, p_dout = 0;
  int mon_bit, mon_byte, setup_len, hi_len, lo_len, rises, wtk_cnt, rv_cnt;
  int ce_rises = 0;
  bit mon_first, mon_rd;
  logic [7:0] mon_sr, mcmd;

  always @(negedge clk) begin
    if (rst_n) begin
      if (ce && !p_ce) begin
        mon_bit = 0; mon_byte = 0; mon_first = 1; setup_len = 0;
        rises = 0; wtk_cnt = 0; rv_cnt = 0; widx = '0; mon_rd = 0;
        ce_rises++;
      end
      if (ce && !sclk && mon_first) setup_len++;
      if (sclk && !p_sclk) begin
        rises++;
        chk(ce, "R3 rising edge with enable low", ce, 1);
        if (mon_first) chk(setup_len >= HALF, "R3 enable setup", setup_len, HALF);
        else chk(lo_len == HALF, "R7 low half width", lo_len, HALF);
        mon_first = 0;
        hi_len = 0;
        if (mon_byte == 0 || !mon_rd) begin
          chk(doe, "R2 line not driven during transmit", doe, 1);
          mon_sr[mon_bit[2:0]] = dout;
        end else begin
          chk(!doe, "R6 line driven in read phase", doe, 0);
        end
      end
      if (!sclk && p_sclk) begin
        chk(hi_len == HALF, "R7 high half width", hi_len, HALF);
        lo_len = 0;
        if (mon_bit == 7) begin
          if (mon_byte == 0) begin
            mcmd = mon_sr; mon_rd = mon_sr[0];
          end else if (!mon_rd && mon_byte <= 16) begin
            wcap[mon_byte-1] = mon_sr;
          end
          mon_byte++;
          mon_bit = 0;
        end else begin
          mon_bit++;
        end
        if (mon_rd && mon_byte >= 1 && mon_byte <= 16)
          din = rbytes[mon_byte-1][mon_bit[2:0]];
        else
          din = 1'($urandom);
      end
      if (sclk) hi_len++; else lo_len++;
      if (sclk && p_sclk) chk(dout == p_dout, "R2 data changed while clock high", dout, p_dout);
      if (p_oe && !doe) chk(!p_dout, "R6 released while driving high", p_dout, 0);
      if (!ce && p_ce) begin
        chk(!sclk, "R3 enable fell with clock high", sclk, 0);
        chk(done, "R9 done missing in first cycle enable low", done, 1);
      end
      if (done) chk(!ce && p_ce, "R9 done not right after enable fall", ce, 0);
      if (wtake) begin widx = widx + 1'b1; wtk_cnt++; end
      if (rvalid) begin
        if (rv_cnt < 16) rcap[rv_cnt] = rdata;
        rv_cnt++;
      end
      p_sclk = sclk; p_ce = ce; p_oe = doe; p_dout = dout;
    end
  end

  task automatic run_txn(input logic [7:0] c, input int n, input bit poke);
    int ce0;
    int t;
    for (int k = 0; k < 16; k++) begin
      wbytes[k] = 8'($urandom);
      rbytes[k] = 8'($urandom);
    end
    ce0 = ce_rises;
    @(negedge clk);
    start = 1'b1; cmd = c; count = CW'(n);
    @(negedge clk);
    start = 1'b0;
    chk(busy, "R9 busy after start", busy, 1);
    if (poke) begin
      repeat (5) @(negedge clk);
      start = 1'b1; cmd = c ^ 8'h01; count = CW'(3);
      @(negedge clk);
      start = 1'b0;
      chk(busy, "R8 still busy", busy, 1);
    end
    t = 0;
    while (!done && t < 5000) begin
      @(negedge clk);
      t++;
    end
    chk(done, "R9 done reached", done, 1);
    @(negedge clk);
    chk(!busy, "R9 busy after done", busy, 0);
    chk(!ce && !sclk && !doe, "R3 pads idle after end", {ce, sclk, doe}, 0);
    chk(mcmd == c, "R2 command byte on line", mcmd, c);
    chk(rises == 8 * (1 + n), "R4 rising edge count", rises, 8 * (1 + n));
    if (c[0]) begin
      chk(rv_cnt == n, "R5 read byte count", rv_cnt, n);
      chk(wtk_cnt == 0, "R5 take during read", wtk_cnt, 0);
      for (int k = 0; k < n; k++) chk(rcap[k] == rbytes[k], "R5 read byte", rcap[k], rbytes[k]);
    end else begin
      chk(wtk_cnt == n, "R4 take count", wtk_cnt, n);
      chk(rv_cnt == 0, "R4 valid during write", rv_cnt, 0);
      for (int k = 0; k < n; k++) chk(wcap[k] == wbytes[k], "R4 written byte", wcap[k], wbytes[k]);
    end
    if (n == 0)
      chk(rises == 8 && wtk_cnt == 0 && rv_cnt == 0, "R10 zero count", rises, 8);
    if (poke) begin
      repeat (30) @(negedge clk);
      chk(ce_rises == ce0 + 1, "R8 extra transaction", ce_rises, ce0 + 1);
      chk(!busy, "R8 busy after ignored start", busy, 0);
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int seed;
    logic [7:0] c;
    seed = $urandom(32'd7);
    for (int k = 0; k < 16; k++) begin wbytes[k] = 8'h0; rbytes[k] = 8'h0; end
    repeat (3) @(negedge clk);
    chk({ce, sclk, doe, busy, done, wtake, rvalid} == 7'b0, "R1 reset state",
        {ce, sclk, doe, busy, done, wtake, rvalid}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!sclk && !ce, "R7 clock idles low", sclk, 0);
    run_txn(8'h81, 1, 0);
    run_txn(8'h80, 1, 0);
    run_txn(8'hBF, 8, 0);
    run_txn(8'hBE, 7, 0);
    run_txn(8'h8E, 0, 0);
    run_txn(8'h81, 0, 0);
    run_txn(8'hBF, 8, 1);
    run_txn(8'h84, 1, 1);
    for (int i = 0; i < 30; i++) begin
      c = {1'b1, 1'b0, {2{1'($urandom)}}, 3'($urandom), 1'($urandom)};
      run_txn(c, int'($urandom % 10), (i % 7) == 3);
    end
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog R9 act=0 exp=1");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule